// File: doc/BRIEF.md
# Serial NAND Page Read Address Sequencer

This block produces the stream of byte addresses that a serial NAND read walks through, for a small array model whose pages carry 2048 main bytes followed by 64 spare bytes (2112 bytes in all). A read is launched with a 16-bit row (upper 10 bits pick the block, lower 6 bits pick the page inside it) and a 12-bit column. While chip select stays low, one address beat comes out per clock, together with a last flag. The bench, or the surrounding logic, looks each address up in the array.

Two read styles exist, chosen by a mode bit that resets to the value of a strap input and that can be rewritten while the sequencer is idle. In page-buffer style (mode 1) the stream begins at the given column and runs to the final spare byte, then stops. In streaming style (mode 0) the column input is disregarded, every page is walked from byte 0 through byte 2047 with its spare bytes skipped, and the stream carries on into the next row with no end of its own. The row after 0xFFFF is 0x0000. Raising chip select ends any read at once.

Top module: `nand_rd_seq`

## Requirements
- R1: After reset the sequencer is idle: busy = 0, addr_valid = 0. mode_buf equals the mode_strap level seen during reset.
- R2: A start pulse is accepted only while the sequencer is idle and cs_n is low. The first beat appears on the following cycle with addr_row = start_row. A start pulse while cs_n is high leaves busy at 0.
- R3: In mode 1 the first beat has addr_col = start_col. Each later beat raises addr_col by one and keeps addr_row unchanged.
- R4: In mode 1 the beat with addr_col = 2111 has addr_last = 1. On the next cycle busy = 0 and addr_valid = 0.
- R5: In mode 0 the first beat has addr_col = 0, whatever start_col holds.
- R6: In mode 0 addr_col never reaches 2048 and addr_last stays 0. After column 2047 the next beat is column 0 of row + 1.
- R7: In mode 0 the row after 0xFFFF (last page of last block) is 0x0000.
- R8: While cs_n is high, addr_valid is 0 in that same cycle and busy is 0 from the next cycle on. Lowering cs_n again without a start does not resume the read.
- R9: A mode_wr pulse loads mode_in into mode_buf only when the sequencer is idle. While busy it is ignored: mode_buf keeps its value and the running read keeps its style.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_strap | input | 1 | Reset value of the mode bit |
| mode_wr | input | 1 | Load mode_in into the mode bit (honoured only when idle) |
| mode_in | input | 1 | New mode: 1 page-buffer, 0 streaming |
| cs_n | input | 1 | Active-low chip select; high aborts |
| start | input | 1 | Launch a read |
| start_row | input | 16 | Block (bits 15:6) and page (bits 5:0) |
| start_col | input | 12 | Start byte, used in mode 1 only |
| mode_buf | output | 1 | Current mode bit |
| busy | output | 1 | A read is in progress |
| addr_valid | output | 1 | Address beat present this cycle |
| addr_row | output | 16 | Row of the current beat |
| addr_col | output | 12 | Column of the current beat |
| addr_last | output | 1 | Final beat of a page-buffer read |

## Verification
A corrupted column or row register shows on addr_col or addr_row at the very next beat, because every beat is compared with a value worked out in the bench. A latched mode that is wrong shows on the first beat as a nonzero or zero start column. A wrong end-of-page decision shows within one cycle after column 2047 or 2111, either as a spare-area column in streaming style or as a missing last flag and a stream that keeps running. A wrong abort path shows one cycle after chip select rises, as busy staying high.

// File: rtl/nand_rd_seq.sv
module nand_rd_seq #(
  parameter int MAIN  = 2048,
  parameter int SPARE = 64,
  parameter int COL_W = 12,
  parameter int BLK_W = 10,
  parameter int PG_W  = 6,
  localparam int ROW_W = BLK_W + PG_W,
  localparam int PAGE  = MAIN + SPARE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_strap,
  input  logic             mode_wr,
  input  logic             mode_in,
  input  logic             cs_n,
  input  logic             start,
  input  logic [ROW_W-1:0] start_row,
  input  logic [COL_W-1:0] start_col,
  output logic             mode_buf,
  output logic             busy,
  output logic             addr_valid,
  output logic [ROW_W-1:0] addr_row,
  output logic [COL_W-1:0] addr_col,
  output logic             addr_last
);

  logic             active, run_buf;
  logic [ROW_W-1:0] row;
  logic [COL_W-1:0] col;

  wire at_end = run_buf && (col >= COL_W'(PAGE - 1));
  wire pg_end = !run_buf && (col == COL_W'(MAIN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      run_buf  <= 1'b0;
      mode_buf <= mode_strap;
      row      <= '0;
      col      <= '0;
    end else begin
      if (mode_wr && !active) mode_buf <= mode_in;
      if (cs_n) begin
        active <= 1'b0;
      end else if (!active) begin
        if (start) begin
          active  <= 1'b1;
          run_buf <= mode_buf;
          row     <= start_row;
          col     <= mode_buf ? start_col : '0;
        end
      end else if (at_end) begin
        active <= 1'b0;
      end else if (pg_end) begin
        col <= '0;
        row <= row + 1'b1;
      end else begin
        col <= col + 1'b1;
      end
    end
  end

  assign busy       = active;
  assign addr_valid = active && !cs_n;
  assign addr_row   = row;
  assign addr_col   = col;
  assign addr_last  = active && at_end;

endmodule

// File: rtl/nand_rd_seq_chk.sv
module nand_rd_seq_chk #(
  parameter int MAIN  = 2048,
  parameter int COL_W = 12,
  parameter int ROW_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             busy,
  input logic             addr_valid,
  input logic [ROW_W-1:0] addr_row,
  input logic [COL_W-1:0] addr_col,
  input logic             addr_last,
  input logic             run_buf
);

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && run_buf && $past(addr_valid) && !$past(addr_last))
      |-> (addr_col == COL_W'($past(addr_col) + 1'b1)) && (addr_row == $past(addr_row)));

  p_end_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && addr_last) |=> (!busy && !addr_valid));

  p_cont_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !run_buf && !$past(busy)) |-> (addr_col == '0));

  p_no_spare_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !run_buf) |-> ((addr_col < COL_W'(MAIN)) && !addr_last));

  p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !busy);

endmodule

bind nand_rd_seq nand_rd_seq_chk #(.MAIN(MAIN), .COL_W(COL_W), .ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .busy(busy), .addr_valid(addr_valid),
  .addr_row(addr_row), .addr_col(addr_col), .addr_last(addr_last), .run_buf(run_buf)
);

// File: tb/sim_nand_rd_seq.sv
`timescale 1ns/1ps
module sim_nand_rd_seq;
  logic clk = 0, rst_n = 0, mode_strap = 1, mode_wr = 0, mode_in = 0;
  logic cs_n = 1, start = 0;
  logic [15:0] start_row = 0;
  logic [11:0] start_col = 0;
  logic mode_buf, busy, addr_valid, addr_last;
  logic [15:0] addr_row;
  logic [11:0] addr_col;
  int checks = 0, fails = 0, cyc = 0;
  bit  done = 0;

  always #2 clk = ~clk;

  nand_rd_seq u0 (.*);

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual cycles %0d expected < 150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step; @(negedge clk); #1; endtask

  task automatic do_reset(input bit strap);
    @(negedge clk); rst_n = 0; mode_strap = strap; cs_n = 1; start = 0; mode_wr = 0;
    step; step; rst_n = 1; #1;
  endtask

  task automatic launch(input logic [15:0] r, input logic [11:0] c);
    @(negedge clk); cs_n = 0; start = 1; start_row = r; start_col = c;
    @(negedge clk); start = 0; #1;
  endtask

  task automatic set_mode(input bit m);
    @(negedge clk); mode_wr = 1; mode_in = m;
    @(negedge clk); mode_wr = 0; #1;
  endtask

  task automatic end_read; @(negedge clk); cs_n = 1; #1; step; endtask

  task automatic t_reset;
    do_reset(1'b1);
    chk(!busy && !addr_valid, "R1 idle", {busy, addr_valid}, 0);
    chk(mode_buf == 1, "R1 strap1", mode_buf, 1);
    do_reset(1'b0);
    chk(mode_buf == 0, "R1 strap0", mode_buf, 0);
  endtask

  task automatic t_start_cs_high;
    @(negedge clk); cs_n = 1; start = 1; start_row = 16'h0123;
    @(negedge clk); start = 0; #1;
    chk(!busy, "R2 start ignored cs_n high", busy, 0);
  endtask

  task automatic t_buf_tail;
    set_mode(1);
    launch(16'h1234, 12'd2100);
    chk(addr_row == 16'h1234, "R2 first row", addr_row, 16'h1234);
    for (int i = 0; i < 12; i++) begin
      chk(addr_valid && addr_col == 12'(2100 + i) && addr_row == 16'h1234, "R3 buffer col",
          addr_col, 2100 + i);
      chk(addr_last == (i == 11), "R4 last flag", addr_last, i == 11);
      step;
    end
    chk(!busy && !addr_valid, "R4 idle after last", {busy, addr_valid}, 0);
    end_read;
  endtask

  task automatic t_buf_full;
    int bad = 0;
    launch(16'h03FF, 12'd0);
    for (int i = 0; i < 2112; i++) begin
      if (!(addr_valid && addr_col == 12'(i) && addr_last == (i == 2111))) bad++;
      step;
    end
    chk(bad == 0, "R3 full page incl spare", bad, 0);
    chk(!busy, "R4 full page ends", busy, 0);
    end_read;
  endtask

  task automatic t_cont(input logic [15:0] r);
    int bad = 0;
    set_mode(0);
    launch(r, 12'd500);
    chk(addr_col == 0 && addr_row == r, "R5 start col zero", addr_col, 0);
    for (int i = 0; i < 2048; i++) begin
      if (!(addr_valid && addr_col == 12'(i) && addr_row == r && !addr_last)) bad++;
      step;
    end
    chk(bad == 0, "R6 main bytes only", bad, 0);
    chk(addr_valid && addr_col == 0 && addr_row == 16'(r + 1), "R6/R7 next page",
        addr_row, 16'(r + 1));
    step;
    chk(addr_col == 1 && !addr_last, "R6 continues", addr_col, 1);
    @(negedge clk); cs_n = 1; #1;
    chk(!addr_valid, "R8 valid drops same cycle", addr_valid, 0);
    step;
    chk(!busy, "R8 idle after abort", busy, 0);
  endtask

  task automatic t_abort_mid;
    set_mode(1);
    launch(16'h0042, 12'd10);
    step; step;
    chk(addr_col == 12, "R3 mid col", addr_col, 12);
    @(negedge clk); cs_n = 1; #1;
    chk(!addr_valid, "R8 abort valid", addr_valid, 0);
    @(negedge clk); cs_n = 0; #1;
    chk(!busy && !addr_valid, "R8 no resume", {busy, addr_valid}, 0);
    step;
    chk(!busy, "R8 still idle", busy, 0);
    end_read;
  endtask

  task automatic t_mode_busy;
    launch(16'h0007, 12'd2040);
    @(negedge clk); mode_wr = 1; mode_in = 0;
    @(negedge clk); mode_wr = 0; #1;
    chk(mode_buf == 1, "R9 write ignored when busy", mode_buf, 1);
    for (int i = 2; i < 72; i++) begin
      if (i == 71) chk(addr_col == 2111 && addr_last, "R9 run keeps buffer style", addr_col, 2111);
      step;
    end
    chk(!busy, "R9 run ended", busy, 0);
    end_read;
    set_mode(0);
    chk(mode_buf == 0, "R9 write when idle", mode_buf, 0);
  endtask

  initial begin
    t_reset;
    t_start_cs_high;
    t_buf_tail;
    t_buf_full;
    t_cont(16'h0041);
    t_cont(16'hFFFF);
    t_abort_mid;
    set_mode(1);
    t_mode_busy;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule